// File: doc/BRIEF.md
# Store Queue with Load Disambiguation

This block keeps every store that has been issued but not yet written to memory, in program order. A store takes a slot at the tail when it is dispatched. It carries the reorder-buffer tag of the store that produces it. Its address and its data arrive later, in any order, through two independent write ports that name the slot. When the retirement logic raises `commit`, the oldest store is sent to memory, provided both its address and its data are present.

A load reads the tail pointer (`tail_snap`) at dispatch and keeps that value. When its address is resolved, it presents the address together with the saved pointer. The queue then compares the address only against the stores that were in flight ahead of that load. One cycle later it returns one of four verdicts:
- stall the load,
- forward the store data,
- forward the producing reorder-buffer tag,
- let the load go to memory.

The `flush` input discards every store still in the queue.

Top module: `store_queue`

## Requirements
- R1: Stores are written to memory strictly in the order they were allocated, each with the address and data written to its own slot.
- R2: When `DEPTH` stores are held, `alloc_ready` is low and a request on `alloc_valid` allocates nothing: `tail_snap` does not move.
- R3: The address and the data of a slot are filled independently, by slot index, in either order and in different cycles.
- R4: `tail_snap` is the tail pointer, with one wrap bit above the slot index, and it advances by one for each accepted allocation. A query compares only the stores between the head and the pointer it supplies. A pointer that the head has already passed selects no store.
- R5: If any of those older stores still lacks its address, the verdict is stall (`ld_resp_kind` = 2'b00), even when another older store matches.
- R6: If the selected matching store holds its data, the verdict is 2'b01 and `ld_resp_data` carries that data.
- R7: If the selected matching store has no data yet, the verdict is 2'b10 and `ld_resp_tag` carries that store's reorder-buffer tag.
- R8: If no older store has the query address, the verdict is 2'b11 (send to memory).
- R9: When several older stores match, the youngest of them, which is closest to the load, is selected.
- R10: The head store retires only in a cycle where `commit` is high and both its address and data are valid. `mem_wr_valid` and its address and data appear on the next cycle.
- R11: `flush` empties the queue: on the next cycle `alloc_ready` is high, and `tail_snap` equals the head position after any retirement made in the flush cycle.
- R12: `ld_resp_valid` is high exactly one cycle after each cycle with `ld_query_valid` high, and low otherwise.
- R13: After reset the queue is empty: `alloc_ready` is high, `tail_snap` is zero, and `mem_wr_valid` and `ld_resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot for a new store |
| alloc_tag | input | TAG_W | Reorder-buffer tag of the new store |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | IDX_W | Slot index given to the allocating store |
| tail_snap | output | IDX_W+1 | Tail pointer with wrap bit, saved by loads at dispatch |
| addr_wr_en | input | 1 | Write a store address |
| addr_wr_idx | input | IDX_W | Slot receiving the address |
| addr_wr_val | input | ADDR_W | Store address |
| data_wr_en | input | 1 | Write store data |
| data_wr_idx | input | IDX_W | Slot receiving the data |
| data_wr_val | input | DATA_W | Store data |
| commit | input | 1 | Retire the head store if it is complete |
| flush | input | 1 | Discard all queued stores |
| mem_wr_valid | output | 1 | A retired store is sent to memory |
| mem_wr_addr | output | ADDR_W | Address of the retired store |
| mem_wr_data | output | DATA_W | Data of the retired store |
| ld_query_valid | input | 1 | A load asks for disambiguation |
| ld_query_addr | input | ADDR_W | Load address |
| ld_query_snap | input | IDX_W+1 | Tail pointer saved by the load at dispatch |
| ld_resp_valid | output | 1 | Verdict valid |
| ld_resp_kind | output | 2 | 00 stall, 01 data, 10 tag, 11 memory |
| ld_resp_data | output | DATA_W | Forwarded data |
| ld_resp_tag | output | TAG_W | Forwarded producer tag |

## Verification
The bench builds the queue with `DEPTH` = 8, a 16-bit address, 32-bit data and a 6-bit tag. It draws load and store addresses from only four values, so multiple matches and youngest-match selection occur often. With eight slots, the full condition is reached regularly, and the 4-bit snapshot pointer wraps many times over the run. Load snapshots are also chosen behind the head, which exercises the case where the load has no older stores.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    LD_STALL    = 2'b00,
    LD_FWD_DATA = 2'b01,
    LD_FWD_TAG  = 2'b10,
    LD_TO_MEM   = 2'b11
  } ld_kind_e;
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic             retire,
  input  logic             flush,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             full
);
  logic [PTR_W-1:0] head_n;

  assign head_n = head + PTR_W'(retire);
  assign full   = (tail - head) == PTR_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
    end else begin
      head <= head_n;
      if (flush)
        tail <= head_n;
      else if (alloc_req && !full)
        tail <= tail + PTR_W'(1);
    end
  end
endmodule

// File: rtl/sq_search.sv
module sq_search
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [PTR_W-1:0]  head,
  input  logic [PTR_W-1:0]  snap,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [DEPTH-1:0]  addr_v,
  input  logic [DEPTH-1:0]  data_v,
  input  logic [ADDR_W-1:0] addr_a [DEPTH],
  input  logic [DATA_W-1:0] data_a [DEPTH],
  input  logic [TAG_W-1:0]  tag_a  [DEPTH],
  output ld_kind_e          kind,
  output logic [DATA_W-1:0] fwd_data,
  output logic [TAG_W-1:0]  fwd_tag
);
  logic [PTR_W-1:0] diff;
  logic [PTR_W-1:0] older_n;
  logic             unknown;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  assign diff    = snap - head;
  assign older_n = (diff > PTR_W'(DEPTH)) ? '0 : diff;

  // Walk from oldest to youngest; a later hit overwrites, so the youngest wins.
  always_comb begin
    unknown = 1'b0;
    hit     = 1'b0;
    hit_idx = '0;
    for (int p = 0; p < DEPTH; p++) begin
      logic [IDX_W-1:0] idx;
      idx = head[IDX_W-1:0] + IDX_W'(p);
      if (PTR_W'(p) < older_n) begin
        if (!addr_v[idx])
          unknown = 1'b1;
        else if (addr_a[idx] == q_addr) begin
          hit     = 1'b1;
          hit_idx = idx;
        end
      end
    end
  end

  always_comb begin
    if (unknown)             kind = LD_STALL;
    else if (!hit)           kind = LD_TO_MEM;
    else if (data_v[hit_idx]) kind = LD_FWD_DATA;
    else                     kind = LD_FWD_TAG;
    fwd_data = data_a[hit_idx];
    fwd_tag  = tag_a[hit_idx];
  end
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic [PTR_W-1:0]  tail_snap,
  input  logic              addr_wr_en,
  input  logic [IDX_W-1:0]  addr_wr_idx,
  input  logic [ADDR_W-1:0] addr_wr_val,
  input  logic              data_wr_en,
  input  logic [IDX_W-1:0]  data_wr_idx,
  input  logic [DATA_W-1:0] data_wr_val,
  input  logic              commit,
  input  logic              flush,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              ld_query_valid,
  input  logic [ADDR_W-1:0] ld_query_addr,
  input  logic [PTR_W-1:0]  ld_query_snap,
  output logic              ld_resp_valid,
  output logic [1:0]        ld_resp_kind,
  output logic [DATA_W-1:0] ld_resp_data,
  output logic [TAG_W-1:0]  ld_resp_tag
);
  logic [PTR_W-1:0]  head, tail;
  logic              full, retire, alloc_fire;
  logic [IDX_W-1:0]  hidx, tidx;
  logic [DEPTH-1:0]  addr_v, data_v;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  ld_kind_e          s_kind;
  logic [DATA_W-1:0] s_data;
  logic [TAG_W-1:0]  s_tag;

  assign hidx       = head[IDX_W-1:0];
  assign tidx       = tail[IDX_W-1:0];
  assign alloc_fire = alloc_valid && !full && !flush;
  assign retire     = commit && (head != tail) && addr_v[hidx] && data_v[hidx];
  assign alloc_ready = !full;
  assign alloc_idx   = tidx;
  assign tail_snap   = tail;

  sq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .alloc_req(alloc_valid), .retire(retire),
    .flush(flush), .head(head), .tail(tail), .full(full)
  );

  // Per-slot fill flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_v <= '0;
      data_v <= '0;
    end else begin
      if (addr_wr_en) addr_v[addr_wr_idx] <= 1'b1;
      if (data_wr_en) data_v[data_wr_idx] <= 1'b1;
      if (alloc_fire) begin
        addr_v[tidx] <= 1'b0;
        data_v[tidx] <= 1'b0;
      end
    end
  end

  // Payload storage, no reset.
  always_ff @(posedge clk) begin
    if (addr_wr_en) addr_q[addr_wr_idx] <= addr_wr_val;
    if (data_wr_en) data_q[data_wr_idx] <= data_wr_val;
    if (alloc_fire) tag_q[tidx] <= alloc_tag;
  end

  sq_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_search (
    .head(head), .snap(ld_query_snap), .q_addr(ld_query_addr),
    .addr_v(addr_v), .data_v(data_v), .addr_a(addr_q), .data_a(data_q), .tag_a(tag_q),
    .kind(s_kind), .fwd_data(s_data), .fwd_tag(s_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_valid  <= 1'b0;
      mem_wr_addr   <= '0;
      mem_wr_data   <= '0;
      ld_resp_valid <= 1'b0;
      ld_resp_kind  <= LD_STALL;
      ld_resp_data  <= '0;
      ld_resp_tag   <= '0;
    end else begin
      mem_wr_valid  <= retire;
      mem_wr_addr   <= addr_q[hidx];
      mem_wr_data   <= data_q[hidx];
      ld_resp_valid <= ld_query_valid;
      ld_resp_kind  <= s_kind;
      ld_resp_data  <= s_data;
      ld_resp_tag   <= s_tag;
    end
  end
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             flush,
  input logic             commit,
  input logic [PTR_W-1:0] tail_snap,
  input logic             mem_wr_valid,
  input logic             ld_query_valid,
  input logic             ld_resp_valid
);
  // R2: a refused allocation leaves the tail where it was
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !alloc_ready && !flush) |=> $stable(tail_snap));

  // R10: no memory write without commit the cycle before
  a_r10_write_needs_commit: assert property (@(posedge clk) disable iff (rst)
    !commit |=> !mem_wr_valid);

  // R11: after a flush there is always room
  a_r11_flush_frees: assert property (@(posedge clk) disable iff (rst)
    flush |=> alloc_ready);

  // R12: one verdict per query, one cycle later
  a_r12_resp_follows_query: assert property (@(posedge clk) disable iff (rst)
    ld_query_valid |=> ld_resp_valid);

  a_r12_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !ld_query_valid |=> !ld_resp_valid);
endmodule

bind store_queue sq_checker #(.PTR_W(PTR_W)) u_sq_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .flush(flush), .commit(commit), .tail_snap(tail_snap), .mem_wr_valid(mem_wr_valid),
  .ld_query_valid(ld_query_valid), .ld_resp_valid(ld_resp_valid)
);

// File: tb/tb_store_queue.sv
module tb_store_queue;
  localparam int DEPTH = 8, ADDR_W = 16, DATA_W = 32, TAG_W = 6;
  localparam int IDX_W = $clog2(DEPTH), PTR_W = IDX_W + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 0; logic [TAG_W-1:0] alloc_tag = 0;
  logic alloc_ready; logic [IDX_W-1:0] alloc_idx; logic [PTR_W-1:0] tail_snap;
  logic addr_wr_en = 0; logic [IDX_W-1:0] addr_wr_idx = 0; logic [ADDR_W-1:0] addr_wr_val = 0;
  logic data_wr_en = 0; logic [IDX_W-1:0] data_wr_idx = 0; logic [DATA_W-1:0] data_wr_val = 0;
  logic commit = 0, flush = 0;
  logic mem_wr_valid; logic [ADDR_W-1:0] mem_wr_addr; logic [DATA_W-1:0] mem_wr_data;
  logic ld_query_valid = 0; logic [ADDR_W-1:0] ld_query_addr = 0; logic [PTR_W-1:0] ld_query_snap = 0;
  logic ld_resp_valid; logic [1:0] ld_resp_kind; logic [DATA_W-1:0] ld_resp_data; logic [TAG_W-1:0] ld_resp_tag;

  always #4 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut (.*);

  int checks = 0, fails = 0;

  // reference model
  int mhead = 0, mtail = 0;
  logic [ADDR_W-1:0] maddr [DEPTH];
  logic [DATA_W-1:0] mdata [DEPTH];
  logic [TAG_W-1:0]  mtag  [DEPTH];
  logic mav [DEPTH];
  logic mdv [DEPTH];
  int qsnap = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void predict(input int snapseq, input logic [ADDR_W-1:0] a,
                                  output logic [1:0] k, output logic [DATA_W-1:0] d,
                                  output logic [TAG_W-1:0] t);
    logic unk = 0;
    k = 2'b11; d = '0; t = '0;
    for (int s = mhead; s < snapseq; s++) begin
      int i = s % DEPTH;
      if (!mav[i]) unk = 1;
      else if (maddr[i] == a) begin
        if (mdv[i]) begin k = 2'b01; d = mdata[i]; end
        else begin k = 2'b10; t = mtag[i]; end
      end
    end
    if (unk) k = 2'b00;
  endfunction

  // One clock: predict from model, advance model, then check outputs.
  task automatic step();
    logic [1:0] ek; logic [DATA_W-1:0] ed; logic [TAG_W-1:0] et;
    logic emw; logic [ADDR_W-1:0] ema; logic [DATA_W-1:0] emd;
    logic eq = ld_query_valid; logic fl = flush;
    int h = mhead % DEPTH;
    ld_query_snap = PTR_W'(qsnap % (2*DEPTH));
    predict(qsnap, ld_query_addr, ek, ed, et);
    emw = commit && (mtail > mhead) && mav[h] && mdv[h];
    ema = maddr[h]; emd = mdata[h];
    if (addr_wr_en) begin maddr[addr_wr_idx] = addr_wr_val; mav[addr_wr_idx] = 1; end
    if (data_wr_en) begin mdata[data_wr_idx] = data_wr_val; mdv[data_wr_idx] = 1; end
    if (alloc_valid && !flush && (mtail - mhead) < DEPTH) begin
      mav[mtail%DEPTH] = 0; mdv[mtail%DEPTH] = 0; mtag[mtail%DEPTH] = alloc_tag; mtail++;
    end
    if (emw) mhead++;
    if (flush) mtail = mhead;
    @(posedge clk); @(negedge clk);
    chk("R12", 64'(ld_resp_valid), 64'(eq));
    if (eq) begin
      case (ek)
        2'b00: chk("R5", 64'(ld_resp_kind), 64'(ek));
        2'b01: begin chk("R6", 64'(ld_resp_kind), 64'(ek)); chk("R3_R9", 64'(ld_resp_data), 64'(ed)); end
        2'b10: begin chk("R7", 64'(ld_resp_kind), 64'(ek)); chk("R9", 64'(ld_resp_tag), 64'(et)); end
        default: chk("R8", 64'(ld_resp_kind), 64'(ek));
      endcase
    end
    chk("R10", 64'(mem_wr_valid), 64'(emw));
    if (emw) begin
      chk("R1", 64'(mem_wr_addr), 64'(ema));
      chk("R1", 64'(mem_wr_data), 64'(emd));
    end
    chk(fl ? "R11" : "R2", 64'(alloc_ready), 64'((mtail - mhead) < DEPTH));
    chk("R4", 64'(tail_snap), 64'(mtail % (2*DEPTH)));
  endtask

  task automatic idle();
    alloc_valid = 0; addr_wr_en = 0; data_wr_en = 0; commit = 0; flush = 0; ld_query_valid = 0;
  endtask

  task automatic do_alloc(input logic [TAG_W-1:0] t);
    idle(); alloc_valid = 1; alloc_tag = t; step();
  endtask

  task automatic wr_addr(input int seq, input logic [ADDR_W-1:0] a);
    idle(); addr_wr_en = 1; addr_wr_idx = IDX_W'(seq % DEPTH); addr_wr_val = a; step();
  endtask

  task automatic wr_data(input int seq, input logic [DATA_W-1:0] d);
    idle(); data_wr_en = 1; data_wr_idx = IDX_W'(seq % DEPTH); data_wr_val = d; step();
  endtask

  task automatic query(input int snapseq, input logic [ADDR_W-1:0] a);
    idle(); ld_query_valid = 1; ld_query_addr = a; qsnap = snapseq; step();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin mav[i] = 0; mdv[i] = 0; maddr[i] = 0; mdata[i] = 0; mtag[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R13: empty after reset
    chk("R13", 64'(alloc_ready), 64'd1);
    chk("R13", 64'(tail_snap), 64'd0);
    chk("R13", 64'(mem_wr_valid), 64'd0);
    chk("R13", 64'(ld_resp_valid), 64'd0);

    // Directed: three stores to one address, youngest wins (R9)
    do_alloc(6'd11); do_alloc(6'd22); do_alloc(6'd33);
    wr_addr(0, 16'h5); wr_data(0, 32'hAAAA0000);
    wr_data(1, 32'hBBBB1111); wr_addr(1, 16'h5);   // R3: data before address
    query(3, 16'h5);                               // R5: slot 2 address unknown
    wr_addr(2, 16'h5);
    query(3, 16'h5);                               // R7: tag 33
    query(2, 16'h5);                               // R6: data of slot 1
    query(0, 16'h5);                               // R8: no older stores
    query(3, 16'h9);                               // R8: no match
    idle(); commit = 1; step();                    // R1/R10: retire slot 0
    query(0, 16'h5);                               // R4: stale snapshot selects nothing
    idle(); commit = 1; step();
    idle(); commit = 1; step();                    // R10: slot 2 lacks data, no retire
    // Fill to full, then a refused allocation (R2)
    for (int i = 0; i < DEPTH; i++) do_alloc(TAG_W'(i));
    idle(); alloc_valid = 1; alloc_tag = 6'h3F; step();
    idle(); flush = 1; commit = 1; step();         // R11
    wr_data(mhead, 32'hCC);

    // Constrained random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int live;
      idle();
      live = mtail - mhead;
      alloc_valid = ($urandom_range(0, 99) < 45);
      alloc_tag = TAG_W'($urandom);
      if (live > 0 && $urandom_range(0, 1)) begin
        int s = mhead + $urandom_range(0, live - 1);
        if (!mav[s%DEPTH]) begin addr_wr_en = 1; addr_wr_idx = IDX_W'(s%DEPTH); addr_wr_val = ADDR_W'($urandom_range(0, 3)); end
      end
      if (live > 0 && $urandom_range(0, 1)) begin
        int s = mhead + $urandom_range(0, live - 1);
        if (!mdv[s%DEPTH]) begin data_wr_en = 1; data_wr_idx = IDX_W'(s%DEPTH); data_wr_val = $urandom; end
      end
      commit = ($urandom_range(0, 99) < 40);
      flush = ($urandom_range(0, 199) == 0);
      ld_query_valid = ($urandom_range(0, 99) < 60);
      ld_query_addr = ADDR_W'($urandom_range(0, 3));
      qsnap = mhead - $urandom_range(0, 2) + $urandom_range(0, live + 2);
      if (qsnap > mtail) qsnap = mtail;
      if (qsnap < 0) qsnap = 0;
      step();
    end
    idle(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule